// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host processor reach the registers of external Ethernet PHYs over the two-wire serial management bus (MDC clock, bidirectional MDIO data). The host programs a small bank of word-wide registers. It sets a clock-speed code and the target PHY and register numbers. A write transaction starts when the host stores the 16-bit write value. A read transaction starts when the host raises the read-request bit. The host then polls an indicator word until the transfer finishes, and for a read it collects the returned data from a status word.

The block builds standard clause-22 frames, 64 MDC periods long. Each frame carries a preamble of 32 ones, then start, opcode, PHY address, register address, turnaround and 16 data bits. The master changes MDIO only when MDC falls and samples returned data when MDC rises. It drops its output enable for the turnaround and data phase of a read so that the PHY can drive the line. A management-reset command aborts a transfer that is in flight. A separate 5-bit register holds the address given to an on-chip serdes interface, so that it can be kept apart from external PHY addresses.

Register map (word address on `wr_addr` / `rd_addr`): 0 configuration, 1 command, 2 address, 3 write data, 4 read data, 5 indicator, 6 serdes address.

Top module: `mdio_master`

## Requirements
- R1: After reset the indicator word reads 0, MDC is low, `mdio_oe` is low, the configuration word reads 8 (the slowest clock code) and the serdes-address word reads 0.
- R2: A write to word 3 while idle sends a frame. The frame is 32 ones, then 01, then opcode 01, then the PHY address (word 2 bits 12:8), then the register number (word 2 bits 4:0), then turnaround 10, then the low 16 bits of the written value. Every field goes out MSB first. `mdio_oe` is high only while a transfer is in progress.
- R3: A read starts only when a write to word 1 takes bit 0 from 0 to 1. Writing 1 when the stored bit is already 1 starts nothing.
- R4: A read frame carries opcode 10. `mdio_oe` is low from the first turnaround bit to the end of the frame. The 16 bits sampled in the data phase, MSB first, become the value of word 4.
- R5: Indicator bit 0 (busy) is set from the clock edge that accepts a start until the end of the frame. That span lasts exactly 64 × divider system-clock cycles.
- R6: Indicator bit 2 (not-valid) is set when a read starts and clears when word 4 is updated. A write frame never sets it.
- R7: MDC has a period of exactly the divider and is low for its first half. The divider comes from configuration bits 3:0 latched at the start of the frame: codes 0..7 give 4, 8, 14, 20, 28, 36, 40 and 48, and any code of 8 or above gives 112. MDC stays low while idle.
- R8: During a frame, MDIO output changes only at clock edges where MDC falls.
- R9: Writes to word 3 or word 1 while busy are ignored. The stored values stay unchanged and no further frame follows.
- R10: Writing configuration bit 31 as 1 aborts any transfer. Busy, not-valid, MDC and `mdio_oe` are all low on the next cycle, and a following transfer runs normally.
- R11: Word 6 stores bits 4:0 of the written value and reads back zero above them.
- R12: The PHY and register addresses are taken from word 2 when the frame starts. Writing word 2 during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address for writes |
| wr_data | input | 32 | Register write value |
| rd_addr | input | 3 | Register word address for reads |
| rd_data | output | 32 | Read value of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | MDIO line value from the pad |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
Assertions check four things on every cycle: MDIO holds still except when MDC falls, the output enable never rises outside a transfer, MDC stays low while idle, and not-valid never outlives busy. They also check that an abort returns the engine to idle and that a write-data store during a transfer leaves the register untouched. The bench covers what no single-cycle property can show. It uses a bit-level PHY responder to check frame contents against the requirements, the exact frame length for several divider codes, the read data landing in the status word, and the 0-to-1 rule for read requests.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int BUS_W      = 32;
    localparam int RA_W       = 3;
    localparam int SEL_W      = 4;
    localparam int HALF_W     = 6;
    localparam int PHYA_W     = 5;
    localparam int MDATA_W    = 16;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_FIRST   = 46;
    localparam int DATA_FIRST = FRAME_BITS - MDATA_W;

    typedef enum logic [RA_W-1:0] {
        RA_CFG   = 3'd0,
        RA_CMD   = 3'd1,
        RA_ADDR  = 3'd2,
        RA_WDATA = 3'd3,
        RA_RDATA = 3'd4,
        RA_IND   = 3'd5,
        RA_TBI   = 3'd6
    } reg_addr_e;

    // Half period of MDC, in system clocks, per clock-select code
    function automatic logic [HALF_W-1:0] half_of(input logic [SEL_W-1:0] sel);
        case (sel)
            4'd0:    half_of = 6'd2;
            4'd1:    half_of = 6'd4;
            4'd2:    half_of = 6'd7;
            4'd3:    half_of = 6'd10;
            4'd4:    half_of = 6'd14;
            4'd5:    half_of = 6'd18;
            4'd6:    half_of = 6'd20;
            4'd7:    half_of = 6'd24;
            default: half_of = 6'd56;
        endcase
    endfunction

    typedef struct packed {
        logic [HALF_W-1:0] half;
        logic [HALF_W-1:0] cnt;
        logic              mdc;
    } clk_state_t;

    typedef struct packed {
        logic                  busy;
        logic                  nv;
        logic                  rd;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
        logic [MDATA_W-1:0]    rx;
        logic [MDATA_W-1:0]    stat;
    } frame_state_t;

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic               cmd;
        logic [PHYA_W-1:0]  phy;
        logic [PHYA_W-1:0]  regn;
        logic [MDATA_W-1:0] wdata;
        logic [PHYA_W-1:0]  tbi;
    } reg_state_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HALF_W-1:0] half_in,
    input  logic              run,
    input  logic              clr,
    output logic              mdc,
    output logic              rise_tick,
    output logic              fall_tick
);

    clk_state_t s_d, s_q;
    logic       tick;

    always_comb begin
        s_d  = s_q;
        tick = run && !clr && (s_q.cnt == s_q.half - 1'b1);
        if (load) begin
            s_d.half = half_in;
        end
        if (!run || clr) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (tick) begin
            s_d.cnt = '0;
            s_d.mdc = ~s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.half <= half_of('1);
        end else begin
            s_q <= s_d;
        end
    end

    assign mdc       = s_q.mdc;
    assign rise_tick = tick && !s_q.mdc;
    assign fall_tick = tick && s_q.mdc;

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc); // R7

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort,
    input  logic               start_wr,
    input  logic               start_rd,
    input  logic [PHYA_W-1:0]  phy,
    input  logic [PHYA_W-1:0]  regn,
    input  logic [MDATA_W-1:0] wdata,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               mdio_i,
    output logic               busy,
    output logic               not_valid,
    output logic [MDATA_W-1:0] stat,
    output logic               mdio_o,
    output logic               mdio_oe
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_FIRST);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_FIRST);

    frame_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (abort) begin
            s_d.busy = 1'b0;
            s_d.nv   = 1'b0;
            s_d.idx  = '0;
        end else if (!s_q.busy && (start_wr || start_rd)) begin
            s_d.busy = 1'b1;
            s_d.nv   = start_rd;
            s_d.rd   = start_rd;
            s_d.idx  = '0;
            s_d.rx   = '0;
            s_d.sh   = {32'hFFFF_FFFF, 2'b01,
                        start_rd ? 2'b10 : 2'b01,
                        phy, regn,
                        start_rd ? 2'b00 : 2'b10,
                        start_rd ? {MDATA_W{1'b0}} : wdata};
        end else if (s_q.busy) begin
            if (rise_tick && s_q.rd && (s_q.idx >= DAT_IDX)) begin
                s_d.rx = {s_q.rx[MDATA_W-2:0], mdio_i};
            end
            if (fall_tick) begin
                if (s_q.idx == LAST_IDX) begin
                    s_d.busy = 1'b0;
                    s_d.idx  = '0;
                    if (s_q.rd) begin
                        s_d.nv   = 1'b0;
                        s_d.stat = s_q.rx;
                    end
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                    s_d.sh  = {s_q.sh[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign not_valid = s_q.nv;
    assign stat      = s_q.stat;
    assign mdio_o    = s_q.busy ? s_q.sh[FRAME_BITS-1] : 1'b1;
    assign mdio_oe   = s_q.busy && !(s_q.rd && (s_q.idx >= TA_IDX));

    AST_NV_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        not_valid |-> busy); // R6

    AST_STAT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !abort && !fall_tick) |=> $stable(stat)); // R4

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RA_W-1:0]    wr_addr,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic [RA_W-1:0]    rd_addr,
    output logic [BUS_W-1:0]   rd_data,
    input  logic               busy,
    input  logic               not_valid,
    input  logic [MDATA_W-1:0] stat,
    output logic               abort,
    output logic               start_wr,
    output logic               start_rd,
    output logic [SEL_W-1:0]   sel,
    output logic [PHYA_W-1:0]  phy,
    output logic [PHYA_W-1:0]  regn,
    output logic [MDATA_W-1:0] start_data
);

    reg_state_t s_d, s_q;
    logic       unused_bits;

    assign unused_bits = ^wr_data[BUS_W-2:MDATA_W];

    always_comb begin
        s_d      = s_q;
        abort    = 1'b0;
        start_wr = 1'b0;
        start_rd = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                RA_CFG: begin
                    s_d.sel = wr_data[SEL_W-1:0];
                    abort   = wr_data[BUS_W-1];
                end
                RA_CMD: begin
                    if (!busy) begin
                        s_d.cmd  = wr_data[0];
                        start_rd = wr_data[0] && !s_q.cmd;
                    end
                end
                RA_ADDR: begin
                    s_d.phy  = wr_data[8 +: PHYA_W];
                    s_d.regn = wr_data[0 +: PHYA_W];
                end
                RA_WDATA: begin
                    if (!busy) begin
                        s_d.wdata = wr_data[MDATA_W-1:0];
                        start_wr  = 1'b1;
                    end
                end
                RA_TBI: s_d.tbi = wr_data[PHYA_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_CFG:   rd_data[SEL_W-1:0]   = s_q.sel;
            RA_CMD:   rd_data[0]           = s_q.cmd;
            RA_ADDR: begin
                rd_data[8 +: PHYA_W] = s_q.phy;
                rd_data[0 +: PHYA_W] = s_q.regn;
            end
            RA_WDATA: rd_data[MDATA_W-1:0] = s_q.wdata;
            RA_RDATA: rd_data[MDATA_W-1:0] = stat;
            RA_IND: begin
                rd_data[0] = busy;
                rd_data[2] = not_valid;
            end
            RA_TBI:   rd_data[PHYA_W-1:0]  = s_q.tbi;
            default:  rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.sel <= 4'd8;
        end else begin
            s_q <= s_d;
        end
    end

    assign sel        = s_q.sel;
    assign phy        = s_q.phy;
    assign regn       = s_q.regn;
    assign start_data = wr_data[MDATA_W-1:0];

    AST_WDATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_WDATA && busy) |=> $stable(s_q.wdata)); // R9

    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(start_wr || start_rd)); // R9

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RA_W-1:0]  wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [RA_W-1:0]  rd_addr,
    output logic [BUS_W-1:0] rd_data,
    output logic             mdc,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe
);

    logic               busy, not_valid, abort, start_wr, start_rd;
    logic               rise_tick, fall_tick;
    logic [SEL_W-1:0]   sel;
    logic [PHYA_W-1:0]  phy, regn;
    logic [MDATA_W-1:0] start_data, stat;

    mdio_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .busy       (busy),
        .not_valid  (not_valid),
        .stat       (stat),
        .abort      (abort),
        .start_wr   (start_wr),
        .start_rd   (start_rd),
        .sel        (sel),
        .phy        (phy),
        .regn       (regn),
        .start_data (start_data)
    );

    mdio_clkgen u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_wr || start_rd),
        .half_in   (half_of(sel)),
        .run       (busy),
        .clr       (abort),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (abort),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .phy       (phy),
        .regn      (regn),
        .wdata     (start_data),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .not_valid (not_valid),
        .stat      (stat),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o)); // R8

    AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy); // R2

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !mdc && !mdio_oe)); // R10

endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd5;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mdio_master u_mdio_master (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int divof(input logic [3:0] s);
        case (s)
            4'd0: return 4;   4'd1: return 8;   4'd2: return 14;  4'd3: return 20;
            4'd4: return 28;  4'd5: return 36;  4'd6: return 40;  4'd7: return 48;
            default: return 112;
        endcase
    endfunction

    // Behavioural reference of busy / not-valid / MDC, compared every clock
    int       m_k = 0, m_div = 112;
    bit       m_busy = 0, m_nv = 0, m_cmd = 0, pre;
    logic [3:0] m_sel = 4'd8;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_nv = 0; m_cmd = 0; m_sel = 4'd8; m_k = 0;
        end else begin
            pre = m_busy;
            if (m_busy) begin
                m_k++;
                if (m_k == 64 * m_div) begin m_busy = 0; m_nv = 0; end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin
                        m_sel = wr_data[3:0];
                        if (wr_data[31]) begin m_busy = 0; m_nv = 0; end
                    end
                    3'd1: if (!pre) begin
                        if (wr_data[0] && !m_cmd) begin
                            m_busy = 1; m_nv = 1; m_k = 0; m_div = divof(m_sel);
                        end
                        m_cmd = wr_data[0];
                    end
                    3'd3: if (!pre) begin
                        m_busy = 1; m_nv = 0; m_k = 0; m_div = divof(m_sel);
                    end
                    default: ;
                endcase
            end
            #1;
            chk("R7 mdc vs model", {31'b0, mdc},
                {31'b0, m_busy && (((m_k / (m_div / 2)) % 2) == 1)});
            if (rd_addr == 3'd5)
                chk("R5/R6 indicator vs model", rd_data, {29'b0, m_nv, 1'b0, m_busy});
        end
    end

    // Bit-level PHY responder
    int          phy_n = 0;
    int          collide = 0;
    logic [0:63] phy_bits;
    logic [15:0] phy_val = 16'h0;

    always @(posedge mdc) begin
        if (phy_n < 64) phy_bits[phy_n] = mdio_o;
        if (phy_n >= 46 && phy_n <= 63 && phy_bits[34] && !phy_bits[35] && mdio_oe)
            collide++;
        phy_n++;
    end

    always @(negedge mdc) begin
        if (phy_n >= 47 && phy_n <= 63 && phy_bits[34] && !phy_bits[35])
            mdio_i = (phy_n == 47) ? 1'b0 : phy_val[63 - phy_n];
        else
            mdio_i = 1'b1;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        rd_addr = 3'd5;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
        @(negedge clk);
        rd_addr = 3'd5;
    endtask

    task automatic wait_idle(output int cnt);
        int guard = 0;
        cnt = 0;
        while (rd_data[0] && guard < 20000) begin
            cnt++; guard++;
            @(negedge clk);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_frame(input string tag, input bit isrd, input logic [4:0] p,
                               input logic [4:0] r, input logic [15:0] d);
        logic [63:0] exp, cap;
        exp = {32'hFFFF_FFFF, 2'b01, isrd ? 2'b10 : 2'b01, p, r,
               isrd ? 2'b00 : 2'b10, isrd ? 16'h0 : d};
        for (int i = 0; i < 64; i++) cap[63 - i] = phy_bits[i];
        chk({tag, " bit count"}, phy_n, 64);
        if (isrd) chk({tag, " header"}, {14'b0, cap[63:46]}, {14'b0, exp[63:46]});
        else begin
            chk({tag, " frame hi"}, cap[63:32], exp[63:32]);
            chk({tag, " frame lo"}, cap[31:0], exp[31:0]);
        end
    endtask

    logic [31:0] v;
    int          n;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 indicator reset", rd_data, 32'h0);
        chk("R1 mdc reset", {31'b0, mdc}, 32'h0);
        chk("R1 oe reset", {31'b0, mdio_oe}, 32'h0);
        rd(3'd0, v); chk("R1 cfg reset", v, 32'd8);
        rd(3'd6, v); chk("R1 tbi reset", v, 32'h0);

        wr(3'd6, 32'hFFFF_FFE3);
        rd(3'd6, v); chk("R11 tbi readback", v, 32'h03);

        // Write frame, divider 4
        wr(3'd0, 32'd0);
        wr(3'd2, {19'b0, 5'h13, 3'b0, 5'h0A});
        phy_n = 0;
        wr(3'd3, 32'h0000_A5C3);
        chk("R6 write leaves not-valid clear", rd_data, 32'h1);
        wait_idle(n);
        chk("R5 write duration div4", n, 256);
        check_frame("R2 write frame", 0, 5'h13, 5'h0A, 16'hA5C3);

        // Interference during a frame, divider 8
        wr(3'd0, 32'd1);
        phy_n = 0;
        wr(3'd3, 32'h0000_0F0F);
        wr(3'd2, {19'b0, 5'h02, 3'b0, 5'h1F});
        wr(3'd3, 32'h0000_1234);
        wr(3'd1, 32'h1);
        wait_idle(n);
        check_frame("R12 address latched", 0, 5'h13, 5'h0A, 16'h0F0F);
        rd(3'd3, v); chk("R9 wdata ignored while busy", v, 32'h0F0F);
        rd(3'd1, v); chk("R9 cmd ignored while busy", v, 32'h0);
        idle_cycles(30);
        chk("R9 no extra frame", rd_data, 32'h0);

        // Read frame, divider 14
        wr(3'd0, 32'd2);
        phy_val = 16'h5E71; phy_n = 0; collide = 0;
        wr(3'd1, 32'h1);
        chk("R6 not-valid set at read start", rd_data, 32'h5);
        wait_idle(n);
        chk("R5 read duration div14", n, 64 * 14);
        chk("R6 not-valid cleared", rd_data, 32'h0);
        rd(3'd4, v); chk("R4 read data", v, 32'h5E71);
        check_frame("R4 read frame", 1, 5'h02, 5'h1F, 16'h0);
        chk("R4 oe released in read phase", collide, 0);

        // Read request level rules
        phy_n = 0;
        wr(3'd1, 32'h1);
        idle_cycles(10);
        chk("R3 repeated 1 starts nothing", rd_data, 32'h0);
        chk("R3 no mdc activity", phy_n, 0);
        wr(3'd0, 32'd7);
        wr(3'd1, 32'h0);
        phy_val = 16'h8001; phy_n = 0; collide = 0;
        wr(3'd1, 32'h1);
        wait_idle(n);
        chk("R7 read duration div48", n, 64 * 48);
        rd(3'd4, v); chk("R3 read after 0-to-1", v, 32'h8001);
        chk("R4 no collision div48", collide, 0);

        // Code above 8 selects 112
        wr(3'd0, 32'd15);
        phy_n = 0;
        wr(3'd3, 32'h0000_FFFE);
        wait_idle(n);
        chk("R7 write duration code15", n, 64 * 112);
        check_frame("R7 frame code15", 0, 5'h02, 5'h1F, 16'hFFFE);

        // Abort
        wr(3'd0, 32'd8);
        wr(3'd3, 32'h0000_3C3C);
        idle_cycles(500);
        wr(3'd0, 32'h8000_0000);
        chk("R10 busy cleared", rd_data, 32'h0);
        chk("R10 mdc low", {31'b0, mdc}, 32'h0);
        chk("R10 oe low", {31'b0, mdio_oe}, 32'h0);
        idle_cycles(5);
        phy_n = 0;
        wr(3'd3, 32'h0000_6006);
        wait_idle(n);
        chk("R10 frame after abort duration", n, 256);
        check_frame("R10 frame after abort", 0, 5'h02, 5'h1F, 16'h6006);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule